// File: doc/BRIEF.md
# Decimal Digit Shifter for Binary-Coded Significands

This block scales an unsigned binary integer significand by a power of ten, which is a shift by whole decimal digits when the significand is held in binary rather than BCD. A 54-bit operand, wide enough for any 16-digit decimal value, is multiplied by 10^S, where S is a 4-bit digit count. The product is exact and comes out 104 bits wide, so nothing is lost even for the largest operand shifted by 15 digits.

The datapath is purely combinational. It is a cascade of four scaling stages, one for each bit of S. Stage k multiplies by 10^(2^k) (10, 100, 10^4, 10^8) when its bit of S is set, and otherwise passes its value through. Each stage multiplies by its constant through shifted copies of the operand merged by 3:2 compressors. Values travel between stages as a sum/carry pair, and a single carry-propagate adder at the end resolves the pair. Operand alignment and normalization logic in a decimal floating-point unit would use it directly.

Top module: `dec_left_shifter`

## Requirements
- R1: For every 54-bit `sig_in` and every `dshift` value 0..15, `prod` equals `sig_in` × 10^`dshift` exactly.
- R2: With `dshift` = 0, `prod` equals `sig_in` zero-extended to 104 bits.
- R3: With `sig_in` = 0, `prod` is 0 for every `dshift`.
- R4: With `sig_in` = 2^54−1 and `dshift` = 15, `prod` is the full untruncated product (2^54−1)×10^15.
- R5: When `dshift` has exactly one bit k set, `prod` equals `sig_in` × 10^(2^k), i.e. ×10, ×100, ×10^4 or ×10^8 for k = 0, 1, 2, 3.
- R6: The lowest `dshift` bits of `prod` are always zero, because 10^S carries the factor 2^S.
- R7: When `dshift` < 8 (bit 3 clear), bits 103..78 of `prod` are zero.
- R8: `prod` is never smaller than `sig_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_in | input | 54 | Unsigned binary significand |
| dshift | input | 4 | Number of decimal digits to shift left (0..15) |
| prod | output | 104 | Exact product sig_in × 10^dshift |

## Verification
The hardest case to reach is a carry that ripples across almost the whole final adder after several stages have built up dense sum and carry vectors. Random operands seldom line up that way. The stimulus therefore mixes random operands with all-ones, alternating, single-bit and near-maximum patterns, and applies every one of them at all sixteen shift values. In particular the all-ones operand at shift 15 drives every stage and fills all 104 output bits.

// File: rtl/dls_pkg.sv
package dls_pkg;

    // Operand and shift widths
    localparam int SIG_W      = 54;
    localparam int SHIFT_W    = 4;
    localparam int STAGES     = SHIFT_W;
    // Largest digit count that can be applied
    localparam int MAX_DIGITS = (1 << SHIFT_W) - 1;
    // Bits needed for 10^MAX_DIGITS: ceil(MAX_DIGITS * log2(10))
    localparam int GROWTH_W   = (MAX_DIGITS * 33220 + 9999) / 10000;
    localparam int PROD_W     = SIG_W + GROWTH_W;

    typedef logic [PROD_W-1:0] word_t;

    // Redundant value: true value is sum + carry
    typedef struct packed {
        word_t sum;
        word_t carry;
    } cs_pair_t;

    // Constant 10^n at product width
    function automatic word_t pow10(input int n);
        word_t r;
        r = word_t'(1);
        for (int i = 0; i < n; i++) begin
            r = r * word_t'(10);
        end
        return r;
    endfunction

    // 3:2 compressor across a full word
    function automatic cs_pair_t csa3(input word_t a, input word_t b, input word_t c);
        cs_pair_t o;
        o.sum   = a ^ b ^ c;
        o.carry = ((a & b) | (a & c) | (b & c)) << 1;
        return o;
    endfunction

endpackage

// File: rtl/dls_stage.sv
module dls_stage
    import dls_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic     en,
    input  cs_pair_t din,
    output cs_pair_t dout
);

    // Fixed scale of this stage: 10^(2^IDX)
    localparam word_t FACTOR = pow10(1 << IDX);

    cs_pair_t scaled;

    // For each set bit of the constant, fold in shifted copies of both
    // halves of the incoming pair; no carry propagation takes place.
    always_comb begin
        scaled = '{sum: '0, carry: '0};
        for (int j = 0; j < PROD_W; j++) begin
            if (FACTOR[j]) begin
                scaled = csa3(scaled.sum, scaled.carry, din.sum << j);
                scaled = csa3(scaled.sum, scaled.carry, din.carry << j);
            end
        end
    end

    assign dout = en ? scaled : din;

endmodule

// File: rtl/dls_cpa.sv
module dls_cpa
    import dls_pkg::*;
(
    input  cs_pair_t pair,
    output word_t    total
);

    // Single carry-propagate resolution of the redundant pair
    assign total = pair.sum + pair.carry;

endmodule

// File: rtl/dec_left_shifter.sv
module dec_left_shifter
    import dls_pkg::*;
(
    input  logic [SIG_W-1:0]   sig_in,
    input  logic [SHIFT_W-1:0] dshift,
    output logic [PROD_W-1:0]  prod
);

    cs_pair_t chain [STAGES+1];

    assign chain[0].sum   = word_t'(sig_in);
    assign chain[0].carry = '0;

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            dls_stage #(.IDX(k)) u_stage (
                .en   (dshift[k]),
                .din  (chain[k]),
                .dout (chain[k+1])
            );
        end
    endgenerate

    dls_cpa u_cpa (
        .pair  (chain[STAGES]),
        .total (prod)
    );

endmodule

// File: rtl/dls_checker.sv
module dls_checker
    import dls_pkg::*;
(
    input logic [SIG_W-1:0]   sig_in,
    input logic [SHIFT_W-1:0] dshift,
    input logic [PROD_W-1:0]  prod
);

    localparam int NARROW_W = SIG_W + 26; // 10^7 < 2^24, margin kept
    localparam int HIGH_LO  = 78;

    word_t low_mask;

    always_comb begin
        low_mask = ~({PROD_W{1'b1}} << dshift);

        // R2: no shift keeps the operand
        a_r2_zero_shift: assert (dshift != '0 || prod == word_t'(sig_in))
            else $error("R2 violated");

        // R3: zero stays zero
        a_r3_zero_input: assert (sig_in != '0 || prod == '0)
            else $error("R3 violated");

        // R6: factor 2^S forces low bits clear
        a_r6_low_zeros: assert ((prod & low_mask) == '0)
            else $error("R6 violated");

        // R7: short shifts leave the top bits clear
        a_r7_upper_clear: assert (dshift[SHIFT_W-1] || prod[PROD_W-1:HIGH_LO] == '0)
            else $error("R7 violated");

        // R8: scaling never reduces the value
        a_r8_not_below: assert (prod >= word_t'(sig_in))
            else $error("R8 violated");
    end

    logic unused_ok;
    assign unused_ok = (NARROW_W > 0);

endmodule

bind dec_left_shifter dls_checker u_chk (
    .sig_in (sig_in),
    .dshift (dshift),
    .prod   (prod)
);

// File: tb/dec_left_shifter_test.sv
`timescale 1ns/1ps
module dec_left_shifter_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [53:0]  sig_in = '0;
    logic [3:0]   dshift = '0;
    logic [103:0] prod;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    dec_left_shifter uut (
        .sig_in (sig_in),
        .dshift (dshift),
        .prod   (prod)
    );

    function automatic logic [103:0] ref_prod(input logic [53:0] v, input int s);
        logic [103:0] r;
        r = {50'd0, v};
        for (int i = 0; i < s; i++) r = r * 104'd10;
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [103:0] act, input logic [103:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (in=%h s=%0d)",
                     req, act, exp, sig_in, dshift);
        end
    endtask

    task automatic apply(input logic [53:0] v, input int s);
        logic [103:0] e;
        logic [103:0] m;
        @(negedge clk);
        sig_in = v;
        dshift = 4'(s);
        @(posedge clk);
        #1;
        e = ref_prod(v, s);
        check(prod === e, "R1", prod, e);
        if (s == 0) check(prod === {50'd0, v}, "R2", prod, {50'd0, v});
        if (v == '0) check(prod === '0, "R3", prod, '0);
        if (s == 1 || s == 2 || s == 4 || s == 8)
            check(prod === e, "R5", prod, e);
        m = ~({104{1'b1}} << s);
        check((prod & m) === '0, "R6", prod & m, '0);
        if (s < 8) check(prod[103:78] === '0, "R7", {78'd0, prod[103:78]}, '0);
        check(prod >= {50'd0, v}, "R8", prod, {50'd0, v});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [103:0] big;
        repeat (3) @(posedge clk);
        #1;
        check(prod === '0, "R3 reset state", prod, '0);
        rst = 1'b0;

        for (int s = 0; s < 16; s++) begin
            apply('0, s);
            apply(54'd1, s);
            apply({54{1'b1}}, s);
            apply({27{2'b10}}, s);
            apply({27{2'b01}}, s);
            apply(54'd9999999999999999, s);
            apply(54'h20000000000000, s);
            apply(54'h3FFFFFFFFFFFFE, s);
            for (int b = 0; b < 54; b += 7) apply(54'd1 << b, s);
            for (int r = 0; r < 120; r++) apply({$urandom, $urandom}, s);
        end

        // R4: widest operand at the widest shift
        apply({54{1'b1}}, 15);
        big = ({50'd0, {54{1'b1}}}) * 104'd1000000000000000;
        check(prod === big, "R4", prod, big);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule